// File: doc/BRIEF.md
# GPIO Pin Configuration Cell

This block controls one general-purpose I/O pin through an 8-bit configuration register. A host loads the register through a simple write port. Writes take effect only while a configuration-mode flag is high, and the register can always be read back. The stored byte sets the pin's direction, its polarity inversion, its drive type (push-pull or open-drain) and its interrupt enable. It also selects whether the pin is a plain GPIO or serves one of three alternate functions. The signals of the alternate functions come from other blocks through dedicated ports.

In GPIO mode the pin drives the host's output bit, inverted when polarity is set, and the direction bit controls the output enable. When an alternate function is selected, that function supplies both the data and the direction, and the direction bit no longer matters. The drive-type setting still applies to an alternate output. Alternate consumers receive the raw pad value without inversion. The exception is one designated function code, which follows the polarity bit. An alternate consumer whose function is not selected sees logic 1. The polarity-adjusted pad input and the interrupt-enable bit go to a group interrupt block.

Top module: `gpio_pin_cell`

## Requirements
- R1: After reset the register reads 0x01: the pin is a GPIO input, not inverted, push-pull, with the interrupt disabled. The pad is not driven.
- R2: A write with wrEn high and cfgMode high loads wrData into the register, and cfgQ shows the new value one clock later. A write while cfgMode is low leaves the register unchanged.
- R3: In GPIO mode (bits 4:3 = 00), bit 0 = 1 makes the pin an input with padOe low. Bit 0 = 0 makes it an output with padOe high in push-pull mode.
- R4: Bit 1 = 1 inverts the GPIO output value (padOut = ~gpioDout) and the input seen on polIn (polIn = ~padIn). polIn follows the pad in every direction and mode.
- R5: Bit 7 = 0 selects push-pull: padOut equals the drive value and padOe equals the drive enable. Bit 7 = 1 selects open-drain: a drive value of 1 releases the pad (padOe = 0), and a value of 0 drives it low (padOe = 1, padOut = 0). The pad is never driven high in open-drain mode. This holds in GPIO mode and for alternate outputs.
- R6: Bits 4:3 = 01, 10 or 11 select alternate function 1, 2 or 3. Index k = code - 1 selects altOut[k] and altOe[k]. The alternate function supplies the drive value (altOut[k], never inverted) and the drive enable (altOe[k]), whatever bit 0 says.
- R7: When an alternate function is selected, its input altIn[k] receives padIn without inversion, whatever bit 1 says. The exception is function code 2 (altIn[1]), which receives padIn XOR bit 1.
- R8: Every altIn bit whose function is not selected is held at 1. This includes all altIn bits in GPIO mode.
- R9: grpIntEn equals bit 5 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMode | input | 1 | Configuration mode active; register writes are allowed only while high |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| cfgQ | output | 8 | Current register contents |
| gpioDout | input | 1 | Output data bit from the GPIO data register |
| polIn | output | 1 | Polarity-adjusted pad input, for readback and the group interrupt block |
| grpIntEn | output | 1 | Interrupt enable for this pin |
| altOut | input | 3 | Output data of alternate functions 1..3 |
| altOe | input | 3 | Drive requests of alternate functions 1..3 |
| altIn | output | 3 | Pad input presented to alternate functions 1..3 |
| padIn | input | 1 | Pad input level |
| padOut | output | 1 | Pad output data |
| padOe | output | 1 | Pad output enable |

## Verification
Some properties are checked by assertions on every cycle. Writes outside configuration mode never change the register. An accepted write appears on the following cycle. The pad is never driven high in open-drain mode. An unselected alternate input always reads 1. A selected alternate function that does not request drive keeps the pad undriven. Only the directed scenarios can show the value mapping: that inversion reaches GPIO data and polIn but not ordinary alternate inputs, that function code 2 alone honours polarity, and that the direction bit is overridden when an alternate function is selected. They also cover the reset encoding and the interrupt-enable bit.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;
  localparam int CFG_W     = 8;
  localparam int FSEL_W    = 2;
  localparam int NUM_ALT   = (1 << FSEL_W) - 1;
  localparam int BIT_DIR   = 0;
  localparam int BIT_POL   = 1;
  localparam int FSEL_LO   = 3;
  localparam int BIT_IEN   = 5;
  localparam int BIT_OD    = 7;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h01;

  typedef struct packed {
    logic               gpioMode;
    logic [NUM_ALT-1:0] altSel;
    logic               cfgOut;
    logic               invert;
    logic               openDrain;
    logic               intEn;
  } pin_strobe_t;
endpackage

// File: rtl/gpio_cfg_ctrl.sv
module gpio_cfg_ctrl
  import gpio_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMode,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgQ,
  output pin_strobe_t      strb
);
  logic [CFG_W-1:0]  cfgReg;
  logic [FSEL_W-1:0] fsel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgReg <= CFG_RESET;
    else if (wrEn && cfgMode) cfgReg <= wrData;
  end

  assign cfgQ = cfgReg;
  assign fsel = cfgReg[FSEL_LO +: FSEL_W];

  always_comb begin
    strb           = '0;
    strb.gpioMode  = (fsel == '0);
    strb.cfgOut    = ~cfgReg[BIT_DIR];
    strb.invert    = cfgReg[BIT_POL];
    strb.openDrain = cfgReg[BIT_OD];
    strb.intEn     = cfgReg[BIT_IEN];
    for (int k = 0; k < NUM_ALT; k++)
      strb.altSel[k] = (fsel == FSEL_W'(k + 1));
  end

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> $stable(cfgQ));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && wrEn) |=> (cfgQ == $past(wrData)));

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.altSel) && (strb.gpioMode == (strb.altSel == '0)));
endmodule

// File: rtl/gpio_pin_path.sv
module gpio_pin_path
  import gpio_cell_pkg::*;
#(
  parameter int POL_FUNC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pin_strobe_t        strb,
  input  logic               gpioDout,
  input  logic [NUM_ALT-1:0] altOut,
  input  logic [NUM_ALT-1:0] altOe,
  input  logic               padIn,
  output logic               padOut,
  output logic               padOe,
  output logic               polIn,
  output logic [NUM_ALT-1:0] altIn
);
  localparam int POL_IDX = POL_FUNC - 1;

  logic drvVal;
  logic drvEn;

  always_comb begin
    drvVal = 1'b0;
    drvEn  = 1'b0;
    if (strb.gpioMode) begin
      drvVal = gpioDout ^ strb.invert;
      drvEn  = strb.cfgOut;
    end else begin
      for (int k = 0; k < NUM_ALT; k++) begin
        if (strb.altSel[k]) begin
          drvVal = altOut[k];
          drvEn  = altOe[k];
        end
      end
    end
  end

  always_comb begin
    if (strb.openDrain) begin
      padOut = 1'b0;
      padOe  = drvEn & ~drvVal;
    end else begin
      padOut = drvVal;
      padOe  = drvEn;
    end
  end

  assign polIn = padIn ^ strb.invert;

  for (genvar k = 0; k < NUM_ALT; k++) begin : g_altin
    if (k == POL_IDX) begin : g_pol
      assign altIn[k] = strb.altSel[k] ? (padIn ^ strb.invert) : 1'b1;
    end else begin : g_raw
      assign altIn[k] = strb.altSel[k] ? padIn : 1'b1;
    end

    // R8
    idle_alt_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.altSel[k] |-> altIn[k]);

    // R6
    alt_release_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.altSel[k] && !altOe[k]) |-> !padOe);
  end

  // R5
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.openDrain |-> !(padOe && padOut));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_cell_pkg::*;
#(
  parameter int POL_FUNC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgMode,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] cfgQ,
  input  logic       gpioDout,
  output logic       polIn,
  output logic       grpIntEn,
  input  logic [2:0] altOut,
  input  logic [2:0] altOe,
  output logic [2:0] altIn,
  input  logic       padIn,
  output logic       padOut,
  output logic       padOe
);
  pin_strobe_t strb;

  gpio_cfg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgMode(cfgMode),
    .wrEn   (wrEn),
    .wrData (wrData),
    .cfgQ   (cfgQ),
    .strb   (strb)
  );

  gpio_pin_path #(.POL_FUNC(POL_FUNC)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .gpioDout(gpioDout),
    .altOut  (altOut),
    .altOe   (altOe),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .polIn   (polIn),
    .altIn   (altIn)
  );

  assign grpIntEn = strb.intEn;
endmodule

// File: tb/tb_gpio_pin_cell.sv
module tb_gpio_pin_cell;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgMode = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] cfgQ;
  logic       gpioDout = 1'b0;
  logic       polIn;
  logic       grpIntEn;
  logic [2:0] altOut = '0;
  logic [2:0] altOe = '0;
  logic [2:0] altIn;
  logic       padIn = 1'b0;
  logic       padOut;
  logic       padOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pin_cell dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .wrEn(wrEn), .wrData(wrData),
    .cfgQ(cfgQ), .gpioDout(gpioDout), .polIn(polIn), .grpIntEn(grpIntEn),
    .altOut(altOut), .altOe(altOe), .altIn(altIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] d, input logic mode);
    @(negedge clk);
    cfgMode = mode; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; cfgMode = 1'b0;
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    check("R1", "cfgQ", cfgQ, 8'h01);
    check("R1", "padOe", {7'd0, padOe}, 8'h00);
    check("R1", "grpIntEn", {7'd0, grpIntEn}, 8'h00);
    check("R8", "altIn gpio", {5'd0, altIn}, 8'h07);
  endtask

  task automatic t_locked();
    cfgWrite(8'hA0, 1'b0);
    check("R2", "locked write", cfgQ, 8'h01);
    check("R9", "intEn after locked", {7'd0, grpIntEn}, 8'h00);
    cfgWrite(8'h20, 1'b1);
    check("R2", "open write", cfgQ, 8'h20);
    check("R9", "intEn set", {7'd0, grpIntEn}, 8'h01);
  endtask

  task automatic t_gpio_out();
    cfgWrite(8'h00, 1'b1);
    gpioDout = 1'b1; settle();
    check("R3", "out oe", {7'd0, padOe}, 8'h01);
    check("R5", "pp high", {7'd0, padOut}, 8'h01);
    gpioDout = 1'b0; settle();
    check("R5", "pp low", {7'd0, padOut}, 8'h00);
    check("R9", "intEn clear", {7'd0, grpIntEn}, 8'h00);
  endtask

  task automatic t_polarity();
    cfgWrite(8'h02, 1'b1);
    gpioDout = 1'b1; padIn = 1'b1; settle();
    check("R4", "inverted out", {7'd0, padOut}, 8'h00);
    check("R4", "inverted polIn", {7'd0, polIn}, 8'h00);
    cfgWrite(8'h03, 1'b1);
    padIn = 1'b0; settle();
    check("R3", "input oe", {7'd0, padOe}, 8'h00);
    check("R4", "input polIn", {7'd0, polIn}, 8'h01);
    cfgWrite(8'h01, 1'b1);
    padIn = 1'b1; settle();
    check("R4", "plain polIn", {7'd0, polIn}, 8'h01);
  endtask

  task automatic t_open_drain();
    cfgWrite(8'h80, 1'b1);
    gpioDout = 1'b1; settle();
    check("R5", "od release", {7'd0, padOe}, 8'h00);
    gpioDout = 1'b0; settle();
    check("R5", "od low oe", {7'd0, padOe}, 8'h01);
    check("R5", "od low val", {7'd0, padOut}, 8'h00);
  endtask

  task automatic t_alt_out();
    cfgWrite(8'h09, 1'b1);
    altOut = 3'b001; altOe = 3'b001; settle();
    check("R6", "alt1 drives despite dir=in", {7'd0, padOe}, 8'h01);
    check("R6", "alt1 value", {7'd0, padOut}, 8'h01);
    altOe = 3'b000; settle();
    check("R6", "alt1 release", {7'd0, padOe}, 8'h00);
    cfgWrite(8'h1A, 1'b1);
    altOut = 3'b100; altOe = 3'b100; settle();
    check("R6", "alt3 not inverted", {7'd0, padOut}, 8'h01);
    cfgWrite(8'h88, 1'b1);
    altOut = 3'b001; altOe = 3'b001; settle();
    check("R5", "alt od release", {7'd0, padOe}, 8'h00);
    altOut = 3'b000; settle();
    check("R5", "alt od low", {6'd0, padOe, padOut}, 8'h02);
    altOut = '0; altOe = '0;
  endtask

  task automatic t_alt_in();
    cfgWrite(8'h0A, 1'b1);
    padIn = 1'b0; settle();
    check("R7", "alt1 raw", {5'd0, altIn}, 8'h06);
    cfgWrite(8'h12, 1'b1);
    padIn = 1'b0; settle();
    check("R7", "alt2 inverted low", {5'd0, altIn}, 8'h07);
    padIn = 1'b1; settle();
    check("R7", "alt2 inverted high", {5'd0, altIn}, 8'h05);
    cfgWrite(8'h1A, 1'b1);
    padIn = 1'b0; settle();
    check("R8", "alt3 sel others idle", {5'd0, altIn}, 8'h03);
    cfgWrite(8'h00, 1'b1); settle();
    check("R8", "gpio all idle", {5'd0, altIn}, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); settle();
    t_reset();
    t_locked();
    t_gpio_out();
    t_polarity();
    t_open_drain();
    t_alt_out();
    t_alt_in();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule